// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

A nine-bit first-in first-out buffer whose write side and read side each run on their own free-running clock. The two clocks may be separate or tied to one net. Each side is qualified by a pair of active-low style enables. On the write side, the second enable also acts as a strobe: when it is low, the word on the data input goes into the threshold registers and is not stored in the FIFO.

Pointers cross between the two domains in Gray code through two-stage synchronizers. Empty and Programmable Almost Empty are computed on the read side. Full and Programmable Almost Full are computed on the write side. The read data is held in an output register. An output-enable input releases the data output, which then reads as zero. Depth is a power-of-two parameter.

Top module: `dc_fifo_pflag`

## Requirements
- R1: A word is stored on a rising write-clock edge when `wr_en1_n` is 0 and `wr_en2_ld` is 1, and the FIFO is not full. Holding both enables in that state stores one word on every write edge.
- R2: A read happens on a rising read-clock edge when `rd_en1_n` and `rd_en2_n` are both 0 and the FIFO is not empty. That edge loads the oldest stored word into the output register, so words leave in the order they were written.
- R3: `full` is 1 when DEPTH words are stored. A write attempted while `full` is 1 leaves the stored words and the pointers unchanged.
- R4: `empty` is 1 when no word is stored. A read attempted while `empty` is 1 leaves the output register and the pointers unchanged.
- R5: After the first write into an empty FIFO, `empty` is still 1 following the next read-clock edge. It goes to 0 after the second read-clock edge, because of the synchronizer.
- R6: `almost_empty` is 1 when the stored word count, as seen on the read side, is less than or equal to the empty-side threshold.
- R7: `almost_full` is 1 when the free space (DEPTH minus the stored count, as seen on the write side) is less than or equal to the full-side threshold.
- R8: When `wr_en1_n` is 0 and `wr_en2_ld` is 0 on a write edge, `din` is loaded into a threshold register and is not stored in the FIFO. The value is truncated to log2(DEPTH)+1 bits. Successive loads alternate between registers: the empty-side threshold first, then the full-side threshold.
- R9: While `oe_n` is 1, `dout` reads 0. While `oe_n` is 0, `dout` shows the output register.
- R10: After reset, the FIFO is empty and not full, `almost_empty` is 1 and `almost_full` is 0. Both thresholds are 7, the next load goes to the empty-side threshold, and the output register is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| wr_en1_n | input | 1 | First write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (1) / threshold load strobe (0) |
| din | input | 9 | Write data or threshold value |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 9 | Read data output |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| almost_empty | output | 1 | Stored count at or below the empty-side threshold |
| almost_full | output | 1 | Free space at or below the full-side threshold |

## Verification
The embedded assertions check, on every edge of their clock, that:
- a blocked write or a threshold load never moves the write pointer;
- a blocked read never moves the read pointer or the output register;
- the Gray pointers change by at most one bit per edge;
- `full` implies `almost_full`, and `empty` implies `almost_empty`.

Only the bench's scenarios can show the data order, the exact lag of `empty` through the synchronizer, and the threshold values at which each almost flag switches. The same holds for the alternation of threshold loads and the output-enable gating.

// File: rtl/dc_fifo_pflag.sv
module dc_fifo_pflag #(
  parameter int DEPTH   = 64,
  parameter int DW      = 9,
  parameter int DEF_OFF = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en1_n,
  input  logic          wr_en2_ld,
  input  logic [DW-1:0] din,
  input  logic          rd_en1_n,
  input  logic          rd_en2_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] wq1, wq2, rq1, rq2;
  logic [PW-1:0] ae_off, af_off;
  logic          ld_sel;
  logic [DW-1:0] q;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  wire wr_req = !wr_en1_n && wr_en2_ld;
  wire ld_req = !wr_en1_n && !wr_en2_ld;
  wire rd_req = !rd_en1_n && !rd_en2_n;
  wire do_wr  = wr_req && !full;
  wire do_rd  = rd_req && !empty;

  wire [PW-1:0] wbin_n = wbin + PW'(do_wr);
  wire [PW-1:0] rbin_n = rbin + PW'(do_rd);

  // write domain
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin   <= '0;
      wgray  <= '0;
      rq1    <= '0;
      rq2    <= '0;
      ae_off <= PW'(DEF_OFF);
      af_off <= PW'(DEF_OFF);
      ld_sel <= 1'b0;
    end else begin
      wbin  <= wbin_n;
      wgray <= (wbin_n >> 1) ^ wbin_n;
      rq1   <= rgray;
      rq2   <= rq1;
      if (ld_req) begin
        if (!ld_sel) ae_off <= PW'(din);
        else         af_off <= PW'(din);
        ld_sel <= !ld_sel;
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (do_wr) mem[wbin[AW-1:0]] <= din;
  end

  // read domain
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
      q     <= '0;
    end else begin
      rbin  <= rbin_n;
      rgray <= (rbin_n >> 1) ^ rbin_n;
      wq1   <= wgray;
      wq2   <= wq1;
      if (do_rd) q <= mem[rbin[AW-1:0]];
    end
  end

  wire [PW-1:0] wcnt = wbin - g2b(rq2);
  wire [PW-1:0] rcnt = g2b(wq2) - rbin;

  assign full         = (wgray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
  assign empty        = (rgray == wq2);
  assign almost_full  = (PW'(DEPTH) - wcnt) <= af_off;
  assign almost_empty = rcnt <= ae_off;
  assign dout         = oe_n ? '0 : q;

  // assertions
  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    (full && wr_req) |=> $stable(wbin));
  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    (empty && rd_req) |=> ($stable(rbin) && $stable(q)));
  p_load_no_store_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    ld_req |=> $stable(wbin));
  p_wgray_step_r1: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));
  p_rgray_step_r2: assert property (@(posedge rclk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)));
  p_full_af_r7: assert property (@(posedge wclk) disable iff (!rst_n)
    full |-> almost_full);
  p_empty_ae_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    empty |-> almost_empty);
endmodule

// File: tb/dc_fifo_pflag_tb.sv
module dc_fifo_pflag_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en1_n = 1, wr_en2_ld = 1, rd_en1_n = 1, rd_en2_n = 1, oe_n = 0;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic empty, full, almost_empty, almost_full;
  int total = 0, bad = 0, cycles = 0;

  always #10 clk = ~clk;

  dc_fifo_pflag u_dut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n),
    .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld), .din(din),
    .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .oe_n(oe_n),
    .dout(dout), .empty(empty), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full));

  // bit 9: 1 = read and expect bits 8:0, 0 = write bits 8:0
  localparam logic [9:0] VEC [10] = '{
    {1'b0, 9'h1A5}, {1'b0, 9'h05A}, {1'b0, 9'h100}, {1'b0, 9'h0FF}, {1'b0, 9'h001},
    {1'b1, 9'h1A5}, {1'b1, 9'h05A}, {1'b1, 9'h100}, {1'b1, 9'h0FF}, {1'b1, 9'h001}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(1);
  endtask

  task automatic push(input logic [8:0] d);
    wr_en1_n = 0; wr_en2_ld = 1; din = d;
    @(negedge clk);
    wr_en1_n = 1;
  endtask

  task automatic load(input logic [8:0] d);
    wr_en1_n = 0; wr_en2_ld = 0; din = d;
    @(negedge clk);
    wr_en1_n = 1; wr_en2_ld = 1;
  endtask

  task automatic pop();
    rd_en1_n = 0; rd_en2_n = 0;
    @(negedge clk);
    rd_en1_n = 1; rd_en2_n = 1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [8:0] hold;
    do_reset();
    // R10 reset state
    chk(empty == 1, "R10 empty", empty, 1);
    chk(full == 0, "R10 full", full, 0);
    chk(almost_empty == 1, "R10 almost_empty", almost_empty, 1);
    chk(almost_full == 0, "R10 almost_full", almost_full, 0);
    chk(dout == 0, "R10 dout", dout, 0);

    // R5 synchronizer lag on first write
    wr_en1_n = 0; wr_en2_ld = 1; din = 9'h1A5;
    @(negedge clk);
    wr_en1_n = 1;
    @(negedge clk);
    chk(empty == 1, "R5 empty after one edge", empty, 1);
    @(negedge clk);
    chk(empty == 0, "R5 empty after two edges", empty, 0);
    pop();
    chk(dout == 9'h1A5, "R2 first word", dout, 9'h1A5);

    // table walk: R1 writes, R2 order
    do_reset();
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][9]) begin
        if (i > 0 && !VEC[i-1][9]) idle(3);
        pop();
        chk(dout == VEC[i][8:0], "R2 order", dout, VEC[i][8:0]);
      end else begin
        push(VEC[i][8:0]);
      end
    end

    // R9 output enable
    oe_n = 1;
    #1;
    chk(dout == 0, "R9 released", dout, 0);
    oe_n = 0;
    #1;
    chk(dout == 9'h001, "R9 driven", dout, 9'h001);

    // R4 read on empty ignored
    pop();
    chk(dout == 9'h001, "R4 read on empty", dout, 9'h001);
    chk(empty == 1, "R4 empty", empty, 1);

    // R1 back-to-back fill, R7 defaults, R3 full
    do_reset();
    wr_en1_n = 0; wr_en2_ld = 1;
    for (int i = 0; i < 64; i++) begin
      din = 9'(i);
      @(negedge clk);
      if (i == 55) chk(almost_full == 0, "R7 af at 56 words", almost_full, 0);
      if (i == 56) chk(almost_full == 1, "R7 af at 57 words", almost_full, 1);
      if (i == 62) chk(full == 0, "R3 not full at 63", full, 0);
    end
    chk(full == 1, "R3 full at 64", full, 1);
    din = 9'h1FF;
    @(negedge clk);
    wr_en1_n = 1;
    chk(full == 1, "R3 still full", full, 1);
    idle(3);
    for (int k = 0; k < 64; k++) begin
      pop();
      chk(dout == 9'(k), "R3 contents after blocked write", dout, k);
      chk(almost_empty == ((64 - k - 1) <= 7), "R6 ae default", almost_empty,
          int'((64 - k - 1) <= 7));
    end
    chk(empty == 1, "R4 empty after drain", empty, 1);
    hold = dout;
    pop();
    chk(dout == hold, "R4 drained read ignored", dout, hold);

    // R8 threshold loads
    do_reset();
    load(9'd3);
    load(9'd10);
    idle(3);
    chk(empty == 1, "R8 loads not stored", empty, 1);
    for (int i = 0; i < 3; i++) push(9'(i));
    idle(3);
    chk(almost_empty == 1, "R8 R6 ae at 3 with off 3", almost_empty, 1);
    push(9'd3);
    idle(3);
    chk(almost_empty == 0, "R8 R6 ae at 4 with off 3", almost_empty, 0);
    for (int i = 4; i < 53; i++) push(9'(i));
    chk(almost_full == 0, "R8 R7 af at 53 with off 10", almost_full, 0);
    push(9'd53);
    chk(almost_full == 1, "R8 R7 af at 54 with off 10", almost_full, 1);
    // third load goes back to empty-side threshold
    load(9'd60);
    idle(3);
    chk(almost_empty == 1, "R8 alternation to ae", almost_empty, 1);
    chk(almost_full == 1, "R8 af unchanged", almost_full, 1);
    pop();
    chk(dout == 9'd0, "R8 first data word intact", dout, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule